// File: doc/BRIEF.md
# Cartridge Banking and Freeze Controller

This block is the register set of a retro home-computer expansion cartridge. The CPU reaches four byte-wide registers through a two-bit register select: a primary control register, an extended control register, a status register and an extended banking register. Together they drive the cartridge's GAME and EXROM lines, a six-bit bank address covering address bits 13 to 18, a RAM/ROM select, and the settings for the I/O window. A memory decoder outside this block consumes these outputs.

A freeze button puts the cartridge into a freeze state. In that state RAM is forced on and the low bank bits are cleared, so that freeze code runs from a known place. A write lock for the ROM is one-way: once software sets it, only a system reset clears it. A mode bit in the status register controls several things. It gates access to the upper bank bits, and while it is low, RAM is confined to 32K. A disable bit takes the whole banking function off the bus until software re-arms it through the status register.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, game, exrom, ram_sel, io_bank_en, clkport_en, io_win_low, map16k and freeze_active are all 0, bank_addr is 0, and rom_wr_ok is 1.
- R2: A write to register 0 works as follows. Bit 0 sets game and bit 1 sets exrom. Bits 3, 4 and 7 set bank_addr[0], [1] and [2], which are address bits 13, 14 and 15. Bit 5 selects RAM (1) or ROM (0). The outputs change on the clock edge that samples the write.
- R3: A write to register 1 works as follows. Bit 0 sets clkport_en, bit 1 sets io_bank_en, bit 6 sets io_win_low, and bit 2 = 1 blocks freeze entry. Bits 3, 4 and 7 set the same three bank bits as register 0, and the later write wins.
- R4: A read of register 0 or register 1 returns the same byte. Bit 0 is rom_wr_ok and bit 1 is the I/O banking enable. Bit 2 is the live freeze button. Bits 3, 4 and 7 are the stored bank bits 13, 14 and 15. Bit 5 is 0 and bit 6 is the window select.
- R5: Writing 1 to bit 0 of register 2 sets the ROM write lock. After that, rom_wr_ok stays 0 and register 2 reads bit 0 as 1 until the next reset. Writing 0 to this bit does not clear the lock.
- R6: A read of register 2 returns the lock at bit 0, the stored GAME and EXROM bits at bits 1 and 2, and the extended-mode bit at bit 6. All other bits read 0. Writing bit 6 of register 2 sets the extended mode.
- R7: Register 3 behaves differently depending on the extended mode. With extended mode set, bits 0 to 2 of a write go to bank_addr[5:3] (address bits 16 to 18), bit 5 goes to map16k, and bit 6 is held. A read returns these fields in the same positions, with the other bits 0. With extended mode clear, writes are ignored and reads return 0.
- R8: When extended mode is clear and ram_sel is 1, bank_addr[5:2] is driven to 0, which limits RAM to 32K. The stored upper bank bits are kept and appear again once ROM is selected.
- R9: A rising edge of freeze_btn has an effect only when freeze is not blocked and not already active. It sets freeze_active, clears bank bits 13 to 15 and the stored RAM bit, and keeps bank bits 16 to 18. ram_sel is forced to 1 while freeze is active. If a register 0 write lands in the same cycle, the freeze entry takes priority over it.
- R10: A register 0 write with bit 6 set clears freeze_active. Freeze is entered again only on a new rising edge of the button, so a button that is still held does not re-enter it.
- R11: A register 0 write with bit 2 set disables the cartridge. While it is disabled, game, exrom, ram_sel, io_bank_en and bank_addr read 0, and writes to registers 0 and 1 are ignored. A register 2 write with bit 6 set re-enables it, and the stored values come back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 primary control, 1 extended control, 2 status, 3 extended banking |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register (combinational) |
| freeze_btn | input | 1 | Freeze button level, already synchronized |
| game | output | 1 | GAME line, asserted high |
| exrom | output | 1 | EXROM line, asserted high |
| bank_addr | output | 6 | Bank address bits 13 to 18 |
| ram_sel | output | 1 | 1 selects RAM, 0 selects ROM |
| io_win_low | output | 1 | I/O RAM/ROM window moved to the lower page |
| io_bank_en | output | 1 | I/O RAM banking enable |
| clkport_en | output | 1 | Clock port enable |
| map16k | output | 1 | 16K mapping select |
| freeze_active | output | 1 | Freeze state |
| rom_wr_ok | output | 1 | ROM writes allowed |

## Verification
The bench aims at the places where state interacts. One is the 32K RAM mask hiding upper bank bits that were loaded earlier; a design that cleared the stored bits would lose them when ROM is selected again. Others are a freeze edge and a control write arriving in the same cycle, a freeze button held through an exit write, and a freeze attempt while freeze is blocked. The bench also writes 0 over the ROM lock, which a design with an ordinary register would clear. It writes to the extended banking register while extended mode is clear, and to control registers while the cartridge is disabled; a design that failed to ignore those writes would show wrong bank bits or wrong line states once it is re-enabled.

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] reg_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       freeze_btn,
  output logic       game,
  output logic       exrom,
  output logic [5:0] bank_addr,
  output logic       ram_sel,
  output logic       io_win_low,
  output logic       io_bank_en,
  output logic       clkport_en,
  output logic       map16k,
  output logic       freeze_active,
  output logic       rom_wr_ok
);
  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_EXT = 2'd1;
  localparam logic [1:0] SEL_STS = 2'd2;
  localparam logic [1:0] SEL_BNK = 2'd3;

  logic       game_r, exrom_r, off, ram_r, frz_act, frz_blk;
  logic       iobank_r, win_r, clkp_r, lock, ext_mode, map_r, ext_en, btn_q;
  logic [2:0] bank_lo, bank_hi;

  wire w_ctl    = wr_en && reg_sel == SEL_CTL && !off;
  wire w_ext    = wr_en && reg_sel == SEL_EXT && !off;
  wire w_sts    = wr_en && reg_sel == SEL_STS;
  wire w_bnk    = wr_en && reg_sel == SEL_BNK && ext_mode;
  wire frz_edge = freeze_btn && !btn_q && !frz_blk && !frz_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      game_r <= 1'b0; exrom_r <= 1'b0; off <= 1'b0; ram_r <= 1'b0;
      frz_act <= 1'b0; frz_blk <= 1'b0; iobank_r <= 1'b0; win_r <= 1'b0;
      clkp_r <= 1'b0; lock <= 1'b0; ext_mode <= 1'b0; map_r <= 1'b0;
      ext_en <= 1'b0; btn_q <= 1'b0; bank_lo <= 3'b0; bank_hi <= 3'b0;
    end else begin
      btn_q <= freeze_btn;
      if (w_ctl) begin
        game_r  <= wr_data[0];
        exrom_r <= wr_data[1];
        if (wr_data[2]) off <= 1'b1;
        bank_lo <= {wr_data[7], wr_data[4], wr_data[3]};
        ram_r   <= wr_data[5];
        if (wr_data[6]) frz_act <= 1'b0;
      end
      if (w_ext) begin
        clkp_r   <= wr_data[0];
        iobank_r <= wr_data[1];
        frz_blk  <= wr_data[2];
        bank_lo  <= {wr_data[7], wr_data[4], wr_data[3]};
        win_r    <= wr_data[6];
      end
      if (w_sts) begin
        if (wr_data[0]) lock <= 1'b1;
        ext_mode <= wr_data[6];
        if (wr_data[6]) off <= 1'b0;
      end
      if (w_bnk) begin
        bank_hi <= wr_data[2:0];
        map_r   <= wr_data[5];
        ext_en  <= wr_data[6];
      end
      if (frz_edge) begin
        frz_act <= 1'b1;
        bank_lo <= 3'b0;
        ram_r   <= 1'b0;
      end
    end
  end

  assign game          = game_r & ~off;
  assign exrom         = exrom_r & ~off;
  assign ram_sel       = ~off & (ram_r | frz_act);
  assign bank_addr     = off ? 6'd0 :
                         (ram_sel && !ext_mode) ? {4'd0, bank_lo[1:0]} :
                         {bank_hi, bank_lo};
  assign io_bank_en    = iobank_r & ~off;
  assign io_win_low    = win_r;
  assign clkport_en    = clkp_r;
  assign map16k        = map_r;
  assign freeze_active = frz_act;
  assign rom_wr_ok     = ~lock;

  always_comb begin
    unique case (reg_sel)
      SEL_CTL, SEL_EXT: rd_data = {bank_lo[2], win_r, 1'b0, bank_lo[1], bank_lo[0],
                                   freeze_btn, iobank_r, ~lock};
      SEL_STS:          rd_data = {1'b0, ext_mode, 3'b0, exrom_r, game_r, lock};
      default:          rd_data = ext_mode ? {1'b0, ext_en, map_r, 2'b0, bank_hi} : 8'h00;
    endcase
  end

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_wr_ok |=> !rom_wr_ok);
  // R9
  frz_lo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frz_act) |-> (bank_lo == 3'b0 && !ram_r));
  // R9
  frz_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frz_act) && !$past(w_bnk)) |-> bank_hi == $past(bank_hi));
  // R7
  bnk_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == SEL_BNK && !ext_mode) |=> ($stable(bank_hi) && $stable(map_r)));
  // R10
  frz_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ctl && wr_data[6] && !frz_edge) |=> !freeze_active);
  // R11
  off_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == SEL_CTL && off) |=> ($stable(game_r) && $stable(exrom_r)));
endmodule

// File: tb/cart_bank_ctrl_test.sv
module cart_bank_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {reg_sel, wr_data, game, exrom, bank_addr, ram_sel}
  localparam logic [18:0] VEC [NVEC] = '{
    {2'd0, 8'h9B, 1'b1, 1'b1, 6'b000111, 1'b0},
    {2'd0, 8'h28, 1'b0, 1'b0, 6'b000001, 1'b1},
    {2'd2, 8'h40, 1'b0, 1'b0, 6'b000001, 1'b1},
    {2'd3, 8'h05, 1'b0, 1'b0, 6'b101001, 1'b1},
    {2'd1, 8'h90, 1'b0, 1'b0, 6'b101110, 1'b1},
    {2'd2, 8'h00, 1'b0, 1'b0, 6'b000010, 1'b1},
    {2'd3, 8'h07, 1'b0, 1'b0, 6'b000010, 1'b1},
    {2'd0, 8'h03, 1'b1, 1'b1, 6'b101000, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, freeze_btn = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] wr_data = 8'h00, rd_data;
  logic game, exrom, ram_sel, io_win_low, io_bank_en, clkport_en, map16k;
  logic freeze_active, rom_wr_ok;
  logic [5:0] bank_addr;
  int total = 0, bad = 0;

  cart_bank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
    .rd_data(rd_data), .freeze_btn(freeze_btn), .game(game), .exrom(exrom),
    .bank_addr(bank_addr), .ram_sel(ram_sel), .io_win_low(io_win_low),
    .io_bank_en(io_bank_en), .clkport_en(clkport_en), .map16k(map16k),
    .freeze_active(freeze_active), .rom_wr_ok(rom_wr_ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; freeze_btn = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    reg_sel = s;
    #1 d = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    do_reset();
    @(negedge clk);
    // R1
    chk("R1 reset outputs", {game, exrom, ram_sel, io_bank_en, clkport_en, io_win_low,
        map16k, freeze_active, rom_wr_ok, bank_addr}, {9'b000000001, 6'd0});

    // R2 R3 R7 R8 table
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][18:17], VEC[i][16:9]);
      chk("R2 R3 R7 R8 table", {game, exrom, bank_addr, ram_sel}, VEC[i][8:0]);
    end

    // R3 R4
    do_reset();
    wr(2'd1, 8'hC3);
    chk("R3 ext ctl outputs", {clkport_en, io_bank_en, io_win_low, bank_addr}, {3'b111, 6'b000100});
    rd(2'd1, r); chk("R4 read ext", r, 8'hC3);
    rd(2'd0, r); chk("R4 read primary", r, 8'hC3);
    wr(2'd1, 8'hC7);
    freeze_btn = 1'b1;
    rd(2'd0, r); chk("R4 live button bit", r, 8'hC7);
    @(negedge clk); @(negedge clk);
    chk("R3 freeze blocked", freeze_active, 1'b0);
    freeze_btn = 1'b0;

    // R6 R5
    do_reset();
    wr(2'd0, 8'h01);
    rd(2'd2, r); chk("R6 status read", r, 8'h02);
    wr(2'd2, 8'h01);
    chk("R5 lock set", rom_wr_ok, 1'b0);
    rd(2'd2, r); chk("R5 status lock bit", r, 8'h03);
    wr(2'd2, 8'h00);
    chk("R5 lock not cleared", rom_wr_ok, 1'b0);
    rd(2'd0, r); chk("R5 ctl read bit0", r[0], 1'b0);
    do_reset();
    @(negedge clk);
    chk("R5 reset clears lock", rom_wr_ok, 1'b1);

    // R7
    wr(2'd2, 8'h40);
    rd(2'd2, r); chk("R6 ext mode bit", r, 8'h40);
    wr(2'd3, 8'h66);
    rd(2'd3, r); chk("R7 ext bank read", r, 8'h66);
    chk("R7 map16k", {map16k, bank_addr}, {1'b1, 6'b110000});
    wr(2'd2, 8'h00);
    rd(2'd3, r); chk("R7 read gated", r, 8'h00);

    // R9 R10
    do_reset();
    wr(2'd2, 8'h40);
    wr(2'd3, 8'h03);
    wr(2'd0, 8'hB8);
    chk("R2 before freeze", {ram_sel, bank_addr}, {1'b1, 6'b011111});
    freeze_btn = 1'b1;
    @(negedge clk);
    chk("R9 freeze entry", {freeze_active, ram_sel, bank_addr}, {2'b11, 6'b011000});
    wr(2'd0, 8'h40);
    chk("R10 exit while held", {freeze_active, ram_sel}, 2'b00);
    repeat (3) @(negedge clk);
    chk("R10 no re-entry while held", freeze_active, 1'b0);
    freeze_btn = 1'b0;
    @(negedge clk);
    freeze_btn = 1'b1;
    @(negedge clk);
    chk("R10 re-entry on new edge", freeze_active, 1'b1);
    freeze_btn = 1'b0;
    wr(2'd0, 8'h40);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = 2'd0; wr_data = 8'h38; freeze_btn = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; freeze_btn = 1'b0;
    chk("R9 freeze beats write", {freeze_active, ram_sel, bank_addr}, {2'b11, 6'b011000});

    // R11
    do_reset();
    wr(2'd0, 8'h0F);
    chk("R11 disabled outputs", {game, exrom, ram_sel, bank_addr}, 9'd0);
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h20);
    wr(2'd2, 8'h40);
    chk("R11 re-enabled", {game, exrom, ram_sel, io_bank_en, bank_addr}, {4'b1100, 6'b000001});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule